// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-wide serial memory of 8192 locations. It runs on a fast system clock and oversamples the two open-drain bus lines, clock and data. From the sampled lines it finds start and stop conditions and checks the slave address against its three strap inputs. It acknowledges by enabling an open-drain pull-down on the data line, then walks the transfer byte by byte. A write transfer carries two array-address bytes and then data bytes. Each accepted data byte goes out on a one-cycle write port. A program-start pulse leaves the block at the stop that closes a write with at least one accepted byte.

Read transfers take their data from a combinational read port indexed by the internal address counter. The read can start at the current counter value, or at an address loaded by a write-mode header that ends in a repeated start. While an external write-cycle controller reports busy, the block does not answer its address, so a master can poll until the program cycle ends. A write-protect input lets the address phase complete but refuses every data byte.

Top module: `tws_mem_slave`

## Requirements
- R1: After reset, and in the cycles right after any detected start or stop, the data-line pull-down (`sda_oe`) is released. No write strobe and no program pulse occur out of reset.
- R2: The first byte after a start is accepted only when bits 7:4 are 1010 and bits 3:1 equal `dev_sel`. Bit 0 selects the direction (1 = read). An address that does not match gets no acknowledge, and the rest of that transfer is ignored until the next start.
- R3: Every accepted byte is acknowledged by holding the data line low through the ninth clock pulse. `sda_oe` changes only right after a detected clock falling edge, or after a start or stop.
- R4: In a write-mode header, the low 5 bits of the first address byte and all 8 bits of the second form the 13-bit location. The top 3 bits of the first byte have no effect.
- R5: Each acknowledged data byte is written at the counter address. The counter then steps within its 32-byte page: the low 5 bits wrap from 31 to 0 and the upper 8 bits are kept.
- R6: A stop that closes a write with at least one accepted data byte gives a one-cycle `prog_go`. A start that interrupts such a write discards that pending program pulse.
- R7: With `wp` high, the slave address and both address bytes are acknowledged, the first data byte is not, nothing is written, and no `prog_go` follows.
- R8: A write-mode header, then a repeated start and a read-mode address, returns the byte at the loaded 13-bit location.
- R9: During a read, each master acknowledge makes the next byte follow. The read counter steps over all 13 bits and wraps from 0x1FFF to 0x0000.
- R10: A master no-acknowledge ends the read and the data line is left released.
- R11: While `wr_busy` is high, a matching slave address is not acknowledged.
- R12: A read-mode address with no header returns the byte one past the last location read or written.
- R13: A start or stop in the middle of a byte abandons the transfer: no write occurs, and the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| dev_sel | input | 3 | Strap value matched against address bits 3:1 |
| wp | input | 1 | Write protect, 1 refuses data bytes |
| wr_busy | input | 1 | Write-cycle controller busy |
| mem_rd_addr | output | 13 | Read address (address counter) |
| mem_rd_data | input | 8 | Read data, valid within one cycle of the address |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_wr_addr | output | 13 | Write address |
| mem_wr_data | output | 8 | Write data |
| prog_go | output | 1 | One-cycle pulse that starts the program cycle |

## Verification
The assertions check on every cycle that the data-line drive moves only right after a clock falling edge or a bus condition, and that it is released after every start and stop. They also check that a write strobe never follows a protected cycle, that a program pulse only ever follows a stop, and that page stepping never disturbs the upper counter bits. Only the bench scenarios can show the transaction-level results. These are which bytes are acknowledged or refused, the data returned by random, sequential and current-address reads, the wrap at the top of the array, the page wrap of written addresses, the refusal while busy, and the loss of a write that a start or stop cuts short.

// File: rtl/tws_pkg.sv
// Shared types for the two-wire memory slave.
// Assumes an 8-bit byte on the bus; the address width is set by the top.
package tws_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } kind_t;
endpackage

// File: rtl/tws_sampler.sv
// Synchronizes the bus clock and data lines into the system clock domain
// and derives clock edges and start/stop conditions from them.
// Assumes both lines idle high; the reset value is the idle level.
module tws_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign raw = {sda_in, scl_in};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            logic [DEPTH-1:0] sh;
            // shift the line through the synchronizer plus one history flop
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[DEPTH-2:0], raw[g]};
            end
            assign cur[g] = sh[DEPTH-2];
            assign prv[g] = sh[DEPTH-1];
        end
    endgenerate

    assign sda_lvl   = cur[1];
    assign scl_rise  = cur[0] & ~prv[0];
    assign scl_fall  = ~cur[0] & prv[0];
    assign start_det = cur[0] & prv[0] & ~cur[1] & prv[1];
    assign stop_det  = cur[0] & prv[0] & cur[1] & ~prv[1];
endmodule

// File: rtl/tws_addr_ctr.sv
// Array address counter: loads a location, steps within a page on writes
// and across the whole array on reads. Load wins over stepping.
module tws_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              inc_page,
    input  logic              inc_lin,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] off_nxt;

    assign off_nxt = addr[PAGE_W-1:0] + PAGE_W'(1);

    // counter update by priority: load, page step, linear step
    always_ff @(posedge clk) begin
        if (!rst_n)        addr <= '0;
        else if (ld)       addr <= ld_val;
        else if (inc_page) addr <= {addr[ADDR_W-1:PAGE_W], off_nxt};
        else if (inc_lin)  addr <= addr + ADDR_W'(1);
    end

    assert_page_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inc_page && !ld) |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/tws_ctrl.sv
// Byte-level protocol engine of the slave: receives address and data bytes,
// decides acknowledge, shifts read data out and follows the master acknowledge.
// Assumes edge/condition strobes from tws_sampler and read data that is
// valid within one cycle of the counter address.
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_lvl,
    input  logic [2:0]        dev_sel,
    input  logic              wp,
    input  logic              wr_busy,
    input  logic [ADDR_W-1:0] ctr_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              ctr_ld,
    output logic [ADDR_W-1:0] ctr_ld_val,
    output logic              ctr_inc_page,
    output logic              ctr_inc_lin,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              prog_go
);
    localparam int HI_W = ADDR_W - BYTE_W;

    phase_t            phase;
    kind_t             kind;
    logic [3:0]        cnt;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-2:0] tx;
    logic [HI_W-1:0]   hi_q;
    logic              ack_q;
    logic              go_tx;
    logic              mack;
    logic              wrote;
    logic              oe_q;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_end;
    logic              byte_ack;
    kind_t             kind_nxt;

    assign rx_byte  = {shreg, sda_lvl};
    assign byte_end = (phase == PH_RX) && scl_rise && (cnt == 4'd7);

    // acknowledge decision for the byte completing on this rising edge
    always_comb begin
        case (kind)
            K_DEV:   byte_ack = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == dev_sel) && !wr_busy;
            K_DATA:  byte_ack = !wp;
            default: byte_ack = 1'b1;
        endcase
    end

    // field that follows the current one in a write-mode header
    always_comb begin
        case (kind)
            K_DEV:   kind_nxt = K_AHI;
            K_AHI:   kind_nxt = K_ALO;
            default: kind_nxt = K_DATA;
        endcase
    end

    assign ctr_ld       = byte_end && (kind == K_ALO);
    assign ctr_ld_val   = {hi_q, rx_byte};
    assign ctr_inc_page = byte_end && (kind == K_DATA) && !wp;
    assign ctr_inc_lin  = (phase == PH_TX) && scl_fall && (cnt == 4'd8);

    // protocol sequencing, bus conditions take priority over bit activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            kind    <= K_DEV;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            hi_q    <= '0;
            ack_q   <= 1'b0;
            go_tx   <= 1'b0;
            mack    <= 1'b0;
            wrote   <= 1'b0;
            oe_q    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            prog_go <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            prog_go <= 1'b0;
            if (start_det) begin
                phase <= PH_RX;
                kind  <= K_DEV;
                cnt   <= '0;
                oe_q  <= 1'b0;
                wrote <= 1'b0;
            end else if (stop_det) begin
                phase   <= PH_IDLE;
                cnt     <= '0;
                oe_q    <= 1'b0;
                prog_go <= wrote;
                wrote   <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise && cnt < 4'd8) begin
                            shreg <= rx_byte[BYTE_W-2:0];
                            cnt   <= cnt + 4'd1;
                            if (cnt == 4'd7) begin
                                ack_q <= byte_ack;
                                case (kind)
                                    K_DEV: go_tx <= rx_byte[0];
                                    K_AHI: hi_q  <= rx_byte[HI_W-1:0];
                                    K_DATA: begin
                                        if (!wp) begin
                                            wr_en   <= 1'b1;
                                            wr_addr <= ctr_addr;
                                            wr_data <= rx_byte;
                                            wrote   <= 1'b1;
                                        end
                                    end
                                    default: ;
                                endcase
                            end
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (ack_q) begin
                                oe_q  <= 1'b1;
                                phase <= PH_ACK;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (kind == K_DEV && go_tx) begin
                                tx    <= rd_data[BYTE_W-2:0];
                                oe_q  <= ~rd_data[BYTE_W-1];
                                phase <= PH_TX;
                            end else begin
                                oe_q  <= 1'b0;
                                kind  <= kind_nxt;
                                phase <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt != 4'd0) begin
                            if (cnt == 4'd8) begin
                                oe_q  <= 1'b0;
                                phase <= PH_MACK;
                            end else begin
                                tx   <= {tx[BYTE_W-3:0], 1'b0};
                                oe_q <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack) begin
                                tx    <= rd_data[BYTE_W-2:0];
                                oe_q  <= ~rd_data[BYTE_W-1];
                                cnt   <= '0;
                                phase <= PH_TX;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = oe_q;

    assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> $past(scl_fall || start_det || stop_det));

    assert_release_on_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det || stop_det) |-> !oe_q);

    assert_prog_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> $past(stop_det));

    assert_no_protected_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!wp));
endmodule

// File: rtl/tws_mem_slave.sv
// Top of the two-wire memory slave: line sampler, protocol engine and
// address counter. Memory storage and the program-cycle timer are outside.
module tws_mem_slave
    import tws_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        dev_sel,
    input  logic              wp,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BYTE_W-1:0] mem_wr_data,
    output logic              prog_go
);
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ctr_ld;
    logic [ADDR_W-1:0] ctr_ld_val;
    logic              ctr_inc_page;
    logic              ctr_inc_lin;
    logic [ADDR_W-1:0] ctr_addr;

    tws_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tws_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_lvl      (sda_lvl),
        .dev_sel      (dev_sel),
        .wp           (wp),
        .wr_busy      (wr_busy),
        .ctr_addr     (ctr_addr),
        .rd_data      (mem_rd_data),
        .sda_oe       (sda_oe),
        .ctr_ld       (ctr_ld),
        .ctr_ld_val   (ctr_ld_val),
        .ctr_inc_page (ctr_inc_page),
        .ctr_inc_lin  (ctr_inc_lin),
        .wr_en        (mem_wr_en),
        .wr_addr      (mem_wr_addr),
        .wr_data      (mem_wr_data),
        .prog_go      (prog_go)
    );

    tws_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ctr_ld),
        .ld_val   (ctr_ld_val),
        .inc_page (ctr_inc_page),
        .inc_lin  (ctr_inc_lin),
        .addr     (ctr_addr)
    );

    assign mem_rd_addr = ctr_addr;
endmodule

// File: tb/sim_tws_mem_slave.sv
// Bench: bus master tasks, a small hashed memory model and a busy timer.
module sim_tws_mem_slave;
    localparam int CLK_P = 10;
    localparam logic [7:0] W_ADR = 8'hAA;
    localparam logic [7:0] R_ADR = 8'hAB;
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h0010_A5, 24'hE123_3C, 24'h1FFE_81,
        24'h00FF_5A, 24'h8800_C3, 24'h1234_0F
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        wp = 1'b0;
    logic        sda_oe;
    logic [12:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en;
    logic [12:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic        prog_go;
    logic        wr_busy;
    logic        sda_line;
    logic [7:0]  mdl [64];
    int          busy_cnt;
    int          prog_cnt;
    int          wr_cnt;
    logic [12:0] last_wa;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign wr_busy  = (busy_cnt != 0);

    function automatic logic [7:0] hsh(input logic [12:0] a);
        return a[12:5] ^ a[7:0];
    endfunction

    function automatic logic [7:0] mread(input logic [12:0] a);
        return mdl[a[5:0]] ^ hsh(a);
    endfunction

    assign mem_rd_data = mread(mem_rd_addr);

    // memory model, busy timer and event counters
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mdl[i] <= 8'h00;
            busy_cnt <= 0;
            prog_cnt <= 0;
            wr_cnt   <= 0;
            last_wa  <= '0;
        end else begin
            if (mem_wr_en) begin
                mdl[mem_wr_addr[5:0]] <= mem_wr_data ^ hsh(mem_wr_addr);
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_wr_addr;
            end
            if (prog_go) begin
                busy_cnt <= 300;
                prog_cnt <= prog_cnt + 1;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    tws_mem_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .sda_oe      (sda_oe),
        .dev_sel     (3'b101),
        .wp          (wp),
        .wr_busy     (wr_busy),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .prog_go     (prog_go)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (4) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic s);
        scl_m = 1'b0; q();
        sda_m = b;    q();
        scl_m = 1'b1; q();
        s = sda_line; q();
    endtask

    task automatic start_c();
        scl_m = 1'b0; q();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
    endtask

    task automatic stop_c();
        scl_m = 1'b0; q();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    task automatic send_b(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(v[i], s);
        bit_x(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_b(input logic give_ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b1, s);
            v = {v[6:0], s};
        end
        bit_x(~give_ack, s);
    endtask

    // write-mode header to an address, all three bytes expected acknowledged
    task automatic hdr(input logic [15:0] a, input string req);
        logic k;
        start_c();
        send_b(W_ADR, k);   chk({req, " dev ack"}, k, 1);
        send_b(a[15:8], k); chk({req, " hi ack"}, k, 1);
        send_b(a[7:0], k);  chk({req, " lo ack"}, k, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       k;
        logic [7:0] d;
        int         p0;
        int         w0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 oe after reset", sda_oe, 0);
        chk("R1 wr_en after reset", mem_wr_en, 0);
        chk("R1 prog after reset", prog_go, 0);

        // vector table: write, busy poll, random read back
        for (int v = 0; v < NVEC; v++) begin
            p0 = prog_cnt;
            hdr(VEC[v][23:8], "R4");
            send_b(VEC[v][7:0], k); chk("R5 data ack", k, 1);
            stop_c();
            chk("R6 prog pulse", prog_cnt, p0 + 1);
            chk("R1 oe after stop", sda_oe, 0);
            start_c();
            send_b(W_ADR, k); chk("R11 busy nack", k, 0);
            stop_c();
            repeat (400) @(negedge clk);
            hdr(VEC[v][23:8], "R8");
            start_c();
            send_b(R_ADR, k); chk("R8 read ack", k, 1);
            recv_b(1'b0, d);
            chk("R8 R4 read back", d, VEC[v][7:0]);
            stop_c();
            chk("R10 oe released", sda_oe, 0);
        end

        // R2: address mismatches
        start_c();
        send_b(8'hA8, k); chk("R2 wrong select nack", k, 0);
        send_b(8'h00, k); chk("R2 ignored after mismatch", k, 0);
        stop_c();
        start_c();
        send_b(8'hBA, k); chk("R2 wrong type nack", k, 0);
        stop_c();

        // R5: page write wrapping inside the page
        p0 = prog_cnt;
        hdr(16'h003E, "R5");
        send_b(8'h11, k); chk("R5 d0 ack", k, 1); chk("R5 wa0", last_wa, 13'h003E);
        send_b(8'h22, k); chk("R5 d1 ack", k, 1); chk("R5 wa1", last_wa, 13'h003F);
        send_b(8'h33, k); chk("R5 d2 ack", k, 1); chk("R5 wa2 wrapped", last_wa, 13'h0020);
        send_b(8'h44, k); chk("R5 d3 ack", k, 1); chk("R5 wa3", last_wa, 13'h0021);
        stop_c();
        chk("R6 page prog", prog_cnt, p0 + 1);
        repeat (400) @(negedge clk);
        hdr(16'h0020, "R9");
        start_c();
        send_b(R_ADR, k); chk("R9 read ack", k, 1);
        recv_b(1'b1, d); chk("R9 seq 0x20", d, 8'h33);
        recv_b(1'b0, d); chk("R9 seq 0x21", d, 8'h44);
        stop_c();

        // R7: write protect
        wp = 1'b1;
        p0 = prog_cnt; w0 = wr_cnt;
        hdr(16'h0050, "R7");
        send_b(8'h99, k); chk("R7 data nack", k, 0);
        stop_c();
        repeat (8) @(negedge clk);
        chk("R7 no write", wr_cnt, w0);
        chk("R7 no prog", prog_cnt, p0);
        wp = 1'b0;

        // R9 wrap across the top, R10 master nack ends read
        hdr(16'h1FFF, "R9");
        start_c();
        send_b(R_ADR, k); chk("R9 read ack", k, 1);
        recv_b(1'b1, d); chk("R9 top byte", d, mread(13'h1FFF));
        recv_b(1'b0, d); chk("R9 wrapped byte", d, mread(13'h0000));
        chk("R10 oe after nack", sda_oe, 0);
        stop_c();

        // R12: current address read
        start_c();
        send_b(R_ADR, k); chk("R12 read ack", k, 1);
        recv_b(1'b0, d); chk("R12 next address", d, mread(13'h0001));
        stop_c();

        // R13: start in the middle of an address byte
        start_c();
        send_b(W_ADR, k); chk("R13 dev ack", k, 1);
        for (int i = 0; i < 3; i++) bit_x(1'b0, k);
        start_c();
        send_b(R_ADR, k); chk("R13 read ack", k, 1);
        recv_b(1'b0, d); chk("R13 counter kept", d, mread(13'h0002));
        stop_c();

        // R13: stop in the middle of a data byte
        p0 = prog_cnt; w0 = wr_cnt;
        hdr(16'h0060, "R13");
        for (int i = 0; i < 3; i++) bit_x(1'b1, k);
        stop_c();
        repeat (8) @(negedge clk);
        chk("R13 no write", wr_cnt, w0);
        chk("R13 no prog", prog_cnt, p0);
        chk("R13 oe released", sda_oe, 0);

        // R6: repeated start after an accepted byte drops the program pulse
        hdr(16'h0060, "R6");
        send_b(8'hD7, k); chk("R6 data ack", k, 1);
        start_c();
        send_b(R_ADR, k); chk("R6 read ack", k, 1);
        recv_b(1'b0, d);
        stop_c();
        repeat (8) @(negedge clk);
        chk("R6 no prog after restart", prog_cnt, p0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule